// File: doc/BRIEF.md
# Clock-Path Delay Eye Calibrator

This block picks a delay setting for the clock leg of a source-synchronous capture interface while the system runs. It steps a programmable clock-path delay through all of its tap values. At each tap it watches the deserialized words coming back from a converter in test mode, which sends a free-running binary count. A tap counts as good only if a whole block of words follows that count exactly. After the last tap, the block takes the longest unbroken run of good taps and loads the tap in the middle of it. Because the search runs at power-up or whenever requested, the result follows the real eye under the current process, voltage and temperature. A setting fixed when the design is built could drift out of the eye.

The delays on the data and frame lanes are tied to zero taps, so only the clock delay moves. Pulsing `start` launches a sweep. `done` then reports completion, `fail` says no tap passed, and `chosen_tap` gives the selected setting. The delay element and the deserializer are outside the block.

Top module: `tap_eye_calibrator`

## Requirements
- R1: A `start` pulse while idle or finished begins a sweep. In the next cycle it clears `done` and `fail`, presents tap 0 and strobes `tap_load`. A `start` pulse during a sweep is ignored.
- R2: Every change of `clk_tap` comes with a `tap_load` pulse exactly one cycle long. In one sweep the taps are presented once each, in ascending order from 0 to 2^TAP_W-1, followed by one final load.
- R3: Every data and frame lane delay output (`data_tap`) is 0 at all times.
- R4: After each tap load, the first SETTLE_WORDS words with `word_valid` high are discarded. Words with `word_valid` low are never counted.
- R5: The next valid word after the settle period is the seed. A tap passes only if each of the following CHECK_WORDS-1 valid words equals the previous word plus 1, modulo 2^WORD_W. The next tap is loaded in the second cycle after the last checked word is sampled.
- R6: Among runs of consecutive passing taps, the longest is selected. If two runs are equally long, the one that starts at the lower tap wins.
- R7: The final tap is floor((first + last) / 2) of the selected run. It is driven on `clk_tap` with a `tap_load` strobe three cycles after the last checked word of tap 2^TAP_W-1 is sampled, and it is also reported on `chosen_tap`.
- R8: If no tap passes, `fail` goes high, the final load presents tap 0, and `chosen_tap` is 0.
- R9: `done` rises the cycle after the final load and stays high until the next `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a calibration sweep |
| word_valid | input | 1 | `word_data` holds a new deserialized word |
| word_data | input | WORD_W | Deserialized test-pattern word |
| clk_tap | output | TAP_W | Tap value for the clock-path delay |
| tap_load | output | 1 | One-cycle strobe: load `clk_tap` into the delay |
| data_tap | output | DATA_LANES*TAP_W | Tap values for data and frame lanes, all zero |
| done | output | 1 | Calibration finished |
| fail | output | 1 | No tap captured the pattern |
| chosen_tap | output | TAP_W | Selected centre tap |

## Verification
Embedded assertions check several properties on every cycle. Tap changes only happen alongside a single-cycle load strobe. An accepted start clears the status and presents tap 0. `done` holds until a new start. The best recorded run never shrinks within a sweep. The checker gives at most one verdict per tap. A failed calibration parks the tap at zero. Only bench scenarios can show that the chosen centre is correct. They use placed eyes, competing runs of equal length, an eye at the top edge, an eye covering every tap, no eye at all, settle-period garbage that must be skipped, gaps in `word_valid`, and counter wrap-around. A cycle-level model checks when each load strobe arrives.

// File: rtl/tapcal_pkg.sv
package tapcal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_MEAS,
    ST_FINISH,
    ST_APPLY,
    ST_DONE
  } cal_state_e;

  // Midpoint of a run given its first tap and length, rounded down.
  function automatic int unsigned window_centre(input int unsigned first,
                                                input int unsigned len);
    return (2 * first + len - 1) / 2;
  endfunction

endpackage

// File: rtl/tapcal_word_checker.sv
module tapcal_word_checker #(
  parameter int WORD_W       = 14,
  parameter int SETTLE_WORDS = 8,
  parameter int CHECK_WORDS  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              meas_done,
  output logic              meas_pass
);
  localparam int TOTAL = SETTLE_WORDS + CHECK_WORDS;
  localparam int CNT_W = $clog2(TOTAL + 1);
  localparam logic [CNT_W-1:0] SEED_IDX = CNT_W'(SETTLE_WORDS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(TOTAL - 1);

  function automatic logic [WORD_W-1:0] successor(input logic [WORD_W-1:0] w);
    return w + 1'b1;
  endfunction

  logic [CNT_W-1:0]  idx;
  logic [WORD_W-1:0] expect_q;
  logic              finished;
  logic              err;

  wire take       = word_valid && !finished && !clear;
  wire in_check   = idx > SEED_IDX;
  wire past_settl = idx >= SEED_IDX;
  wire mismatch   = take && in_check && (word_data != expect_q);
  wire last_word  = take && (idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx       <= '0;
      expect_q  <= '0;
      finished  <= 1'b1;
      err       <= 1'b0;
      meas_done <= 1'b0;
      meas_pass <= 1'b0;
    end else if (clear) begin
      idx       <= '0;
      finished  <= 1'b0;
      err       <= 1'b0;
      meas_done <= 1'b0;
    end else begin
      meas_done <= 1'b0;
      if (take) begin
        idx <= idx + 1'b1;
        if (past_settl) expect_q <= successor(word_data);
        if (mismatch) err <= 1'b1;
        if (last_word) begin
          finished  <= 1'b1;
          meas_done <= 1'b1;
          meas_pass <= !(err || mismatch);
        end
      end
    end
  end

  // R5: one verdict per measurement, never back-to-back
  p_one_verdict_r5: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done |=> !meas_done);

endmodule

// File: rtl/tapcal_window_tracker.sv
module tapcal_window_tracker #(
  parameter int TAP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             upd,
  input  logic [TAP_W-1:0] upd_tap,
  input  logic             upd_pass,
  output logic [TAP_W-1:0] best_first,
  output logic [TAP_W:0]   best_len
);
  logic [TAP_W-1:0] run_first;
  logic [TAP_W:0]   run_len;
  logic [TAP_W-1:0] new_first;
  logic [TAP_W:0]   new_len;

  always_comb begin
    new_first = (run_len == '0) ? upd_tap : run_first;
    new_len   = upd_pass ? run_len + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_first  <= '0;
      run_len    <= '0;
      best_first <= '0;
      best_len   <= '0;
    end else if (clear) begin
      run_first  <= '0;
      run_len    <= '0;
      best_first <= '0;
      best_len   <= '0;
    end else if (upd) begin
      run_first <= new_first;
      run_len   <= new_len;
      // strict compare keeps the earlier run on a tie (R6)
      if (upd_pass && (new_len > best_len)) begin
        best_first <= new_first;
        best_len   <= new_len;
      end
    end
  end

  // R6: the best run found in a sweep never shrinks
  p_best_grows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> best_len >= $past(best_len));

endmodule

// File: rtl/tap_eye_calibrator.sv
module tap_eye_calibrator #(
  parameter int TAP_W        = 5,
  parameter int WORD_W       = 14,
  parameter int SETTLE_WORDS = 8,
  parameter int CHECK_WORDS  = 64,
  parameter int DATA_LANES   = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic                        word_valid,
  input  logic [WORD_W-1:0]           word_data,
  output logic [TAP_W-1:0]            clk_tap,
  output logic                        tap_load,
  output logic [DATA_LANES*TAP_W-1:0] data_tap,
  output logic                        done,
  output logic                        fail,
  output logic [TAP_W-1:0]            chosen_tap
);
  import tapcal_pkg::*;

  localparam logic [TAP_W-1:0] TAP_LAST = '1;

  cal_state_e       state;
  logic [TAP_W-1:0] tap_q;
  logic [TAP_W-1:0] chosen_q;
  logic             done_q;
  logic             fail_q;
  logic             meas_done;
  logic             meas_pass;
  logic [TAP_W-1:0] best_first;
  logic [TAP_W:0]   best_len;
  logic [TAP_W-1:0] centre_tap;

  // named events for the assertions
  wire start_acc  = start && ((state == ST_IDLE) || (state == ST_DONE));
  wire meas_clear = (state == ST_LOAD);
  wire tap_update = (state == ST_MEAS) && meas_done;

  assign centre_tap = TAP_W'(window_centre(32'(best_first), 32'(best_len)));

  tapcal_word_checker #(
    .WORD_W(WORD_W), .SETTLE_WORDS(SETTLE_WORDS), .CHECK_WORDS(CHECK_WORDS)
  ) checker_i (
    .clk(clk), .rst_n(rst_n), .clear(meas_clear),
    .word_valid(word_valid), .word_data(word_data),
    .meas_done(meas_done), .meas_pass(meas_pass)
  );

  tapcal_window_tracker #(.TAP_W(TAP_W)) tracker_i (
    .clk(clk), .rst_n(rst_n), .clear(start_acc),
    .upd(tap_update), .upd_tap(tap_q), .upd_pass(meas_pass),
    .best_first(best_first), .best_len(best_len)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      tap_q    <= '0;
      chosen_q <= '0;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: if (start) begin
          state    <= ST_LOAD;
          tap_q    <= '0;
          chosen_q <= '0;
          done_q   <= 1'b0;
          fail_q   <= 1'b0;
        end
        ST_LOAD: state <= ST_MEAS;
        ST_MEAS: if (meas_done) begin
          if (tap_q == TAP_LAST) state <= ST_FINISH;
          else begin
            tap_q <= tap_q + 1'b1;
            state <= ST_LOAD;
          end
        end
        ST_FINISH: begin
          state <= ST_APPLY;
          if (best_len == '0) begin
            fail_q   <= 1'b1;
            tap_q    <= '0;
            chosen_q <= '0;
          end else begin
            tap_q    <= centre_tap;
            chosen_q <= centre_tap;
          end
        end
        ST_APPLY: begin
          done_q <= 1'b1;
          state  <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign clk_tap    = tap_q;
  assign tap_load   = (state == ST_LOAD) || (state == ST_APPLY);
  assign data_tap   = '0;
  assign done       = done_q;
  assign fail       = fail_q;
  assign chosen_tap = chosen_q;

  // R2: load strobe lasts one cycle
  p_load_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tap_load |=> !tap_load);

  // R2: the tap never moves without a strobe
  p_tap_moves_with_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_tap) |-> tap_load);

  // R1: accepted start clears status and presents tap 0
  p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (tap_load && !done && !fail && clk_tap == '0));

  // R8: failure parks the clock tap at zero
  p_fail_parks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fail) |-> (clk_tap == '0 && chosen_tap == '0));

  // R9: done holds until a new start
  p_done_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

endmodule

// File: tb/tap_eye_calibrator_tb_top.sv
module tap_eye_calibrator_tb_top;
  localparam int TAP_W = 5, WORD_W = 14, SETTLE = 8, CHECK = 64, LANES = 4;
  localparam int NTAPS = 1 << TAP_W;
  localparam int TOTAL = SETTLE + CHECK;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, word_valid = 1'b0;
  logic [WORD_W-1:0] word_data = '0;
  logic [TAP_W-1:0] clk_tap, chosen_tap;
  logic tap_load, done, fail;
  logic [LANES*TAP_W-1:0] data_tap;

  always #2 clk = ~clk;

  tap_eye_calibrator #(.TAP_W(TAP_W), .WORD_W(WORD_W), .SETTLE_WORDS(SETTLE),
    .CHECK_WORDS(CHECK), .DATA_LANES(LANES)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .word_valid(word_valid),
    .word_data(word_data), .clk_tap(clk_tap), .tap_load(tap_load),
    .data_tap(data_tap), .done(done), .fail(fail), .chosen_tap(chosen_tap));

  int tests = 0, fails = 0;
  task automatic check(input bit ok, input string tag, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // eye model and reference state
  logic [NTAPS-1:0] pass_map = '0;
  int exp_final = 0; bit exp_fail = 0;
  bit start_req = 0, sweeping = 0, measuring = 0;
  int cyc = 0, load_no = 0, load_due = -1, done_due = -1;
  int m_cnt = 0, settle_left = 0, applied_tap = 0;
  logic [WORD_W-1:0] counter = 14'h3FF8;  // wraps early in the run

  task automatic compute_expect();
    int best_s = 0, best_l = 0, run_s = 0, run_l = 0;
    for (int t = 0; t < NTAPS; t++) begin
      if (pass_map[t]) begin
        if (run_l == 0) run_s = t;
        run_l++;
        if (run_l > best_l) begin best_l = run_l; best_s = run_s; end
      end else run_l = 0;
    end
    exp_fail  = (best_l == 0);
    exp_final = exp_fail ? 0 : (best_s + best_s + best_l - 1) / 2;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_load, v;
      cyc++;
      check(data_tap == '0, "R3 data lanes at zero", int'(data_tap), 0);
      exp_load = (cyc == load_due);
      check(tap_load == exp_load, "R2/R5 load strobe timing", int'(tap_load), int'(exp_load));
      if (tap_load && exp_load) begin
        if (load_no < NTAPS) check(int'(clk_tap) == load_no, "R2 tap order", int'(clk_tap), load_no);
        else check(int'(clk_tap) == exp_final, "R7 final tap load", int'(clk_tap), exp_final);
      end
      check(done == (done_due >= 0 && cyc >= done_due), "R9 done level", int'(done),
            int'(done_due >= 0 && cyc >= done_due));
      // start request (R1: ignored by the model while sweeping)
      start <= 1'b0;
      if (start_req) begin
        start_req = 0;
        start <= 1'b1;
        if (!sweeping) begin
          sweeping = 1; load_no = 0; load_due = cyc + 1; done_due = -1;
        end
      end
      // word source: settle garbage, then counter or corrupted counter
      v = ($urandom % 4) != 0;
      word_valid <= v;
      if (v) begin
        if (settle_left > 0) begin
          word_data <= counter ^ 14'h1555;
          settle_left--;
        end else if (pass_map[applied_tap] || counter[0])
          word_data <= counter;
        else
          word_data <= counter ^ 14'h0A5A;
        counter = counter + 1'b1;
        if (measuring) begin
          m_cnt++;
          if (m_cnt == TOTAL) begin
            measuring = 0;
            load_due = cyc + ((load_no == NTAPS) ? 3 : 2);
          end
        end
      end
      // model reacts to an observed strobe after driving this cycle's word
      if (tap_load && exp_load) begin
        applied_tap = int'(clk_tap);
        settle_left = SETTLE;
        if (load_no < NTAPS) begin
          measuring = 1; m_cnt = 0; load_no++;
        end else begin
          sweeping = 0; done_due = cyc + 1;
        end
      end
    end
  end

  task automatic run_sweep(input logic [NTAPS-1:0] eye, input bool_mid_start, input string name);
    pass_map = eye;
    compute_expect();
    start_req = 1;
    repeat (3) @(negedge clk);
    if (bool_mid_start) begin
      repeat (500) @(negedge clk);
      start_req = 1;  // R1: must be ignored mid-sweep
    end
    wait (done === 1'b1);
    repeat (20) @(negedge clk);
    check(int'(chosen_tap) == exp_final, {"R7 chosen centre (R4 R5 R6) ", name},
          int'(chosen_tap), exp_final);
    check(int'(clk_tap) == exp_final, {"R7 clk_tap parked ", name}, int'(clk_tap), exp_final);
    check(fail == exp_fail, {"R8 fail flag ", name}, int'(fail), int'(exp_fail));
    check(done == 1'b1, {"R9 done held ", name}, int'(done), 1);
  endtask

  typedef bit bool_t;
  initial begin
    repeat (5) @(negedge clk);
    check(done == 0 && fail == 0 && tap_load == 0, "R1 reset status", int'({done, fail, tap_load}), 0);
    check(clk_tap == '0 && chosen_tap == '0, "R2 reset tap", int'(clk_tap), 0);
    check(data_tap == '0, "R3 reset data lanes", int'(data_tap), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_sweep(32'h0003_FC00, 1, "single eye 10..17");       // centre 13
    run_sweep(32'h0FF0_0078, 0, "two eyes, longer wins");   // 20..27 -> 23
    run_sweep(32'h0000_F03C, 0, "tie, lower start wins");   // 2..5 -> 3
    run_sweep(32'h0000_0000, 0, "no eye");                  // fail, 0
    run_sweep(32'hF000_0000, 0, "eye at top edge");         // 28..31 -> 29
    run_sweep(32'hFFFF_FFFF, 0, "all taps pass");           // 0..31 -> 15
    run_sweep(32'h0000_0001, 0, "single tap 0");            // 0
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule